// File: doc/BRIEF.md
# Parity-Checked Memory Unit Controller with Write Locks

This block runs the read and write cycles of one memory unit on behalf of whichever port has already been granted the unit. On an accepted request it latches the address, data, parity and write key. It decides whether the address falls inside the unit's configured window, and it checks odd byte parity on the incoming address and data. It then consults a small table of two-bit page locks against the write key. After that it performs the access on a synchronous array of 36-bit words (32 data bits plus four hidden byte-parity bits). Two cycles after acceptance it returns a one-cycle done strobe with read data, freshly generated read parity and an 8-bit status word.

The window starts at a configured word address and spans 1K or 2K words (by default, selected by a configuration pin). In two-way interleave mode the window is twice as wide. In that mode the unit claims only addresses whose least significant bit equals its configured side, and the offset shifted right by one indexes the array. A request the unit does not claim still completes with a done strobe, and its status reports the miss. Arbitration, bus drivers and the processor sit outside the block.

Top module: `mem_unit_ctl`

## Requirements
- R1: With interleave off, an address A is claimed when cfg_start <= A < cfg_start + capacity. An unclaimed request sets status bit 2, touches neither the array nor the locks, returns rsp_rdata = 0 and never sets status bits 5 or 7.
- R2: The capacity is 1024 words when cfg_big = 0 and 2048 words when cfg_big = 1.
- R3: With cfg_ilv = 1 the window is 2 x capacity words from cfg_start. Only addresses with A[0] = cfg_side are claimed, and the array index is (A - cfg_start) >> 1.
- R4: Parity is odd per byte: parity bit i covers data bits [8i+7:8i], so that those nine bits hold an odd count of ones. rsp_rpar is always that parity of rsp_rdata, so it is 4'hF after reset.
- R5: req_apar must equal the odd parity bit over all of req_addr. On a mismatch the unit sets status bit 3, performs no store and no read, and returns rsp_rdata = 0.
- R6: On a write, a req_wpar that differs from the odd parity of req_wdata sets status bit 4, and the array is left unchanged.
- R7: Locks hold 2 bits per 128-word page, and the page number is the array index >> 7. The lock port writes them, and reset clears them to 00. A claimed write stores only if the lock is 00, the key is 00, or the key equals the lock. Otherwise it sets status bit 5 and does not store.
- R8: A claimed read with good address parity returns the stored 32 data bits. If the stored parity bits disagree with the stored data, it sets status bit 6. Words never written read as all zeros, including parity, and so set bit 6.
- R9: A request is accepted only while the unit is idle. rsp_done is high for exactly the one cycle that follows the second rising edge after the accepting edge. req_valid seen while a cycle is in progress is ignored.
- R10: The status layout is: bit 0 cycle complete (always 1 on done), bit 1 write, bit 2 unclaimed, bit 3 address parity error, bit 4 data parity error, bit 5 lock violation, bit 6 stored parity error, bit 7 store performed. The status word and rsp_rdata change only with rsp_done and are held in between.
- R11: After reset rsp_done, rsp_status and rsp_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 18 | First word address of the unit's window |
| cfg_big | input | 1 | 1 selects double capacity |
| cfg_ilv | input | 1 | 1 enables two-way interleave |
| cfg_side | input | 1 | Address LSB this unit claims when interleaved |
| lock_we | input | 1 | Write strobe for the lock table |
| lock_page | input | 4 | Page whose lock is written |
| lock_val | input | 2 | New lock value |
| req_valid | input | 1 | Request from the granted port |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 18 | Word address |
| req_apar | input | 1 | Odd parity bit over req_addr |
| req_wdata | input | 32 | Write data |
| req_wpar | input | 4 | Odd byte parity of req_wdata |
| req_key | input | 2 | Write key |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_rpar | output | 4 | Odd byte parity of rsp_rdata |
| rsp_status | output | 8 | Status word of the last cycle |

## Verification
On every cycle the assertions check the shape of each completion. The done strobe lasts one cycle and carries the complete bit. The status and read data hold between strobes. An unclaimed request, a bad address parity, a bad data parity or a lock violation never reports a store, and the first two never return data. Only the bench's scenarios can show that a store really reaches the right index and survives, with interleaved and linear decoding landing on the same word. They also show that the window edges fall exactly at capacity and twice capacity, that each lock and key combination allows or blocks the store, and that a request arriving mid-cycle is dropped. A behavioural model of the array and locks is compared with the outputs on every clock.

// File: rtl/mem_unit_ctl.sv
module mem_unit_ctl #(
  parameter int ADDR_W   = 18,
  parameter int SMALL_AW = 10,
  parameter int PAGE_W   = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           cfg_start,
  input  logic                        cfg_big,
  input  logic                        cfg_ilv,
  input  logic                        cfg_side,
  input  logic                        lock_we,
  input  logic [SMALL_AW-PAGE_W:0]    lock_page,
  input  logic [1:0]                  lock_val,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_apar,
  input  logic [31:0]                 req_wdata,
  input  logic [3:0]                  req_wpar,
  input  logic [1:0]                  req_key,
  output logic                        rsp_done,
  output logic [31:0]                 rsp_rdata,
  output logic [3:0]                  rsp_rpar,
  output logic [7:0]                  rsp_status
);
  localparam int BIG_AW = SMALL_AW + 1;
  localparam int PG_W   = BIG_AW - PAGE_W;
  localparam int PAGES  = 1 << PG_W;
  localparam int DEPTH  = 1 << BIG_AW;

  function automatic logic [3:0] opar(input logic [31:0] d);
    for (int i = 0; i < 4; i++) opar[i] = ~^d[8*i +: 8];
  endfunction

  typedef enum logic [1:0] {IDLE, ACC, FIN} st_t;
  st_t st;

  logic [35:0] mem [DEPTH];
  logic [35:0] ram_q;
  logic [1:0]  locks [PAGES];

  wire [ADDR_W:0] off  = {1'b0, req_addr} - {1'b0, cfg_start};
  wire [ADDR_W:0] span = (ADDR_W+1)'(1) << (SMALL_AW + int'(cfg_big) + int'(cfg_ilv));
  wire hit_n   = (off < span) && (!cfg_ilv || req_addr[0] == cfg_side);
  wire [BIG_AW-1:0] idx_n = cfg_ilv ? off[BIG_AW:1] : off[BIG_AW-1:0];
  wire aperr_n = req_apar != ~^req_addr;
  wire dperr_n = req_write && (req_wpar != opar(req_wdata));

  logic              r_hit, r_wr, r_aperr, r_dperr, r_store, r_lockv, r_rd;
  logic [BIG_AW-1:0] r_idx;
  logic [31:0]       r_data;
  logic [3:0]        r_par;
  logic [1:0]        r_key;

  wire [1:0] lk      = locks[r_idx[BIG_AW-1:PAGE_W]];
  wire       lock_ok = (lk == 2'b00) || (r_key == 2'b00) || (r_key == lk);
  wire       go      = r_hit && !r_aperr;
  wire       store   = go && r_wr && !r_dperr && lock_ok;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = '0;

  always_ff @(posedge clk) begin
    if (st == ACC) begin
      if (store) mem[r_idx] <= {r_par, r_data};
      ram_q <= mem[r_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) locks[p] <= 2'b00;
    end else if (lock_we) begin
      locks[lock_page] <= lock_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      {r_hit, r_wr, r_aperr, r_dperr, r_store, r_lockv, r_rd} <= '0;
      r_idx <= '0; r_data <= '0; r_par <= '0; r_key <= '0;
      rsp_done <= 1'b0; rsp_rdata <= '0; rsp_status <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          st      <= ACC;
          r_hit   <= hit_n;
          r_idx   <= idx_n;
          r_wr    <= req_write;
          r_aperr <= aperr_n;
          r_dperr <= dperr_n;
          r_data  <= req_wdata;
          r_par   <= req_wpar;
          r_key   <= req_key;
        end
        ACC: begin
          st      <= FIN;
          r_store <= store;
          r_lockv <= go && r_wr && !lock_ok;
          r_rd    <= go && !r_wr;
        end
        default: begin
          st         <= IDLE;
          rsp_done   <= 1'b1;
          rsp_rdata  <= r_rd ? ram_q[31:0] : 32'h0;
          rsp_status <= {r_store, r_rd && (ram_q[35:32] != opar(ram_q[31:0])),
                         r_lockv, r_dperr, r_aperr, !r_hit, r_wr, 1'b1};
        end
      endcase
    end
  end

  assign rsp_rpar = opar(rsp_rdata);
endmodule

// File: rtl/mem_unit_ctl_chk.sv
module mem_unit_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_done,
  input logic [31:0] rsp_rdata,
  input logic [7:0]  rsp_status
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_complete_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_status[0]);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> ($stable(rsp_status) && $stable(rsp_rdata)));
  p_store_is_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status[7]) |-> rsp_status[1]);
  p_unclaimed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status[2]) |-> (!rsp_status[7] && !rsp_status[5] && rsp_rdata == 32'h0));
  p_apar_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status[3]) |-> (!rsp_status[7] && rsp_rdata == 32'h0));
  p_dpar_nostore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status[4]) |-> !rsp_status[7]);
  p_lock_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status[5]) |-> !rsp_status[7]);
endmodule

bind mem_unit_ctl mem_unit_ctl_chk chk_i (.*);

// File: tb/mem_unit_ctl_tb_top.sv
module mem_unit_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [17:0] cfg_start = 18'h01000;
  logic cfg_big = 0, cfg_ilv = 0, cfg_side = 0;
  logic lock_we = 0; logic [3:0] lock_page = 0; logic [1:0] lock_val = 0;
  logic req_valid = 0, req_write = 0, req_apar = 0;
  logic [17:0] req_addr = 0; logic [31:0] req_wdata = 0;
  logic [3:0] req_wpar = 0; logic [1:0] req_key = 0;
  logic rsp_done; logic [31:0] rsp_rdata; logic [3:0] rsp_rpar; logic [7:0] rsp_status;
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mem_unit_ctl dut_i (.*);

  function automatic logic [3:0] bpar(input logic [31:0] d);
    for (int i = 0; i < 4; i++) bpar[i] = ~^d[8*i +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [35:0] mmem [int];
  logic [1:0]  mlock [16];
  int   mstage = 0;
  logic e_done = 0; logic [7:0] e_st = 0, p_st = 0; logic [31:0] e_rd = 0, p_rd = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mstage = 0; e_done = 0; e_st = 0; e_rd = 0;
      for (int p = 0; p < 16; p++) mlock[p] = 2'b00;
    end else begin
      e_done = 0;
      if (mstage == 2) begin
        e_done = 1; e_st = p_st; e_rd = p_rd; mstage = 0;
      end else if (mstage == 1) begin
        mstage = 2;
      end else if (req_valid) begin
        int off, span, idx; bit hit, ap, dp, lok, lkv, rd, sto; logic [35:0] w; logic [1:0] lk;
        off  = int'(req_addr) - int'(cfg_start);
        span = 1024 * (cfg_big ? 2 : 1) * (cfg_ilv ? 2 : 1);
        hit  = off >= 0 && off < span && (!cfg_ilv || req_addr[0] == cfg_side);
        idx  = cfg_ilv ? off / 2 : off;
        ap   = req_apar != ~^req_addr;
        dp   = req_write && req_wpar != bpar(req_wdata);
        lk   = hit ? mlock[idx / 128] : 2'b00;
        lok  = lk == 0 || req_key == 0 || req_key == lk;
        lkv  = hit && !ap && req_write && !lok;
        sto  = hit && !ap && req_write && !dp && lok;
        rd   = hit && !ap && !req_write;
        w    = (rd && mmem.exists(idx)) ? mmem[idx] : 36'h0;
        if (sto) mmem[idx] = {req_wpar, req_wdata};
        p_rd = rd ? w[31:0] : 32'h0;
        p_st = {sto, rd && (w[35:32] != bpar(w[31:0])), lkv, dp, ap, !hit, req_write, 1'b1};
        mstage = 1;
      end
      if (lock_we) mlock[lock_page] = lock_val;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R9 model done", {31'b0, rsp_done}, {31'b0, e_done});
    chk("R10 model status", {24'b0, rsp_status}, {24'b0, e_st});
    chk("R8 model rdata", rsp_rdata, e_rd);
    chk("R4 model rpar", {28'b0, rsp_rpar}, {28'b0, bpar(e_rd)});
  end

  task automatic op(input bit wr, input logic [17:0] a, input logic [31:0] d, input logic [1:0] key,
                    input bit bad_ap, input bit bad_dp, input logic [7:0] exp_st,
                    input logic [31:0] exp_rd, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_key = key;
    req_apar = (~^a) ^ bad_ap; req_wpar = bpar(d) ^ {3'b0, bad_dp};
    @(negedge clk); req_valid = 0;
    @(negedge clk); chk({tag, " R9 not yet done"}, {31'b0, rsp_done}, 32'h0);
    @(negedge clk); chk({tag, " R9 done"}, {31'b0, rsp_done}, 32'h1);
    chk({tag, " status"}, {24'b0, rsp_status}, {24'b0, exp_st});
    chk({tag, " rdata"}, rsp_rdata, exp_rd);
    if (!wr) chk({tag, " R4 rpar"}, {28'b0, rsp_rpar}, {28'b0, bpar(exp_rd)});
  endtask

  task automatic set_lock(input logic [3:0] p, input logic [1:0] v);
    @(negedge clk); lock_we = 1; lock_page = p; lock_val = v;
    @(negedge clk); lock_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset done", {31'b0, rsp_done}, 32'h0);
    chk("R11 reset status", {24'b0, rsp_status}, 32'h0);
    chk("R11 reset rdata", rsp_rdata, 32'h0);
    chk("R4 reset rpar", {28'b0, rsp_rpar}, 32'hF);
    rst_n = 1;

    op(0, 18'h01005, 0, 0, 0, 0, 8'h41, 0, "R8 unwritten");
    op(1, 18'h01005, 32'hA5C3_0F01, 0, 0, 0, 8'h83, 0, "R10 write ok");
    op(0, 18'h01005, 0, 0, 0, 0, 8'h01, 32'hA5C3_0F01, "R8 readback");
    op(1, 18'h00FFF, 32'h1234_5678, 0, 0, 0, 8'h07, 0, "R1 below window");
    op(0, 18'h01400, 0, 0, 0, 0, 8'h05, 0, "R1 at start+cap");
    op(0, 18'h013FF, 0, 0, 0, 0, 8'h41, 0, "R1 last word");
    op(0, 18'h01005, 0, 0, 1, 0, 8'h09, 0, "R5 bad addr parity");
    op(1, 18'h01006, 32'hFFFF_0000, 0, 0, 1, 8'h13, 0, "R6 bad data parity");
    op(0, 18'h01006, 0, 0, 0, 0, 8'h41, 0, "R6 array unchanged");

    set_lock(4'd2, 2'b01);
    op(1, 18'h01100, 32'hDEAD_BEEF, 2'b10, 0, 0, 8'h23, 0, "R7 key mismatch");
    op(0, 18'h01100, 0, 0, 0, 0, 8'h41, 0, "R7 blocked store");
    op(1, 18'h01100, 32'hDEAD_BEEF, 2'b01, 0, 0, 8'h83, 0, "R7 key match");
    op(1, 18'h01101, 32'h0000_0001, 2'b00, 0, 0, 8'h83, 0, "R7 key zero");
    op(1, 18'h01180, 32'h8080_8080, 2'b11, 0, 0, 8'h83, 0, "R7 lock zero");
    op(0, 18'h01100, 0, 0, 0, 0, 8'h01, 32'hDEAD_BEEF, "R7 stored");

    cfg_big = 1;
    op(0, 18'h01400, 0, 0, 0, 0, 8'h41, 0, "R2 big claims start+1K");
    op(0, 18'h017FF, 0, 0, 0, 0, 8'h41, 0, "R2 big last word");
    op(0, 18'h01800, 0, 0, 0, 0, 8'h05, 0, "R2 big beyond");
    cfg_big = 0;

    cfg_ilv = 1; cfg_side = 1;
    op(1, 18'h01001, 32'h0F0F_3C3C, 0, 0, 0, 8'h83, 0, "R3 ilv write side1");
    op(0, 18'h01000, 0, 0, 0, 0, 8'h05, 0, "R3 wrong side");
    op(0, 18'h017FF, 0, 0, 0, 0, 8'h41, 0, "R3 ilv last word");
    op(0, 18'h01801, 0, 0, 0, 0, 8'h05, 0, "R3 ilv beyond");
    op(0, 18'h0100B, 0, 0, 0, 0, 8'h01, 32'hA5C3_0F01, "R3 ilv index");
    cfg_ilv = 0;
    op(0, 18'h01000, 0, 0, 0, 0, 8'h01, 32'h0F0F_3C3C, "R3 same word linear");

    begin : busy_drop
      int dones = 0;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 18'h01005; req_apar = ~^18'h01005;
      @(negedge clk);
      req_addr = 18'h00010; req_apar = ~^18'h00010;
      @(negedge clk); req_valid = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (rsp_done) begin
          dones++;
          chk("R9 first request served", {24'b0, rsp_status}, 32'h01);
        end
      end
      chk("R9 busy request ignored", dones, 1);
    end

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule